// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable single-clock burst memory whose depth is set by a parameter. Every rising clock edge captures the address, write data, chip selects, address strobes, burst advance and write enables. A read shows its data at the output within the same cycle as the edge that captured its address, with no output register in the path. Writes take effect at the edge that ends the cycle, using the address and data captured at the start of it.

The word is 18 bits wide and split into two 9-bit lanes. Each lane is 8 data bits plus 1 parity bit, and each lane has its own write enable. A global write enable forces both lanes to be written. Either of two address strobes starts a burst. After the first beat, a 2-bit offset counter produces the next three addresses, in interleaved or linear order. Three chip selects gate every access. The read output is enabled asynchronously. A sleep input blocks new activity and keeps the stored contents.

Top module: `burst_sram_ft`

## Requirements
- R1: Address and controls are captured on the rising edge of `clk_i`. After a read is loaded, `rdata_o` shows the stored word at that address before the next rising edge.
- R2: An access is selected only when `sel_n_i` is 0, `sel_hi_i` is 1 and `sel2_n_i` is 0. A load while deselected ends any burst and leaves the output undriven.
- R3: Either strobe loads `addr_i` and resets the burst offset to 0. `ctl_strobe_n_i` wins when both strobes are low. `cpu_strobe_n_i` is ignored while `sel_n_i` is 1.
- R4: A cycle started by `cpu_strobe_n_i` alone is always a read, and its write enables are ignored. A cycle started by `ctl_strobe_n_i` writes as its enables request.
- R5: The offset steps only when `advance_n_i` is low and no strobe loads. With neither a strobe nor an advance, the access repeats at the same address.
- R6: When `order_lin_i` is 0 (interleaved order), the two low address bits are the loaded low bits XOR the offset.
- R7: When `order_lin_i` is 1 (linear order), the two low address bits are the loaded low bits plus the offset, modulo 4. The upper bits never change during a burst, and the offset wraps after four beats.
- R8: Lane a is word bits [8:0], with bit 8 as its parity. Lane b is bits [17:9], with bit 17 as its parity. `lane_we_n_i[0]` low writes lane a and `lane_we_n_i[1]` low writes lane b. An unselected lane keeps its old value.
- R9: `all_we_n_i` low writes both lanes, whatever `lane_we_n_i` holds.
- R10: `rdata_oe_o` is 1 only while `out_en_n_i` is low and the current access is a selected read. It follows `out_en_n_i` without a clock edge. `rdata_o` is 0 whenever `rdata_oe_o` is 0.
- R11: While `sleep_i` is 1 at an edge, no access is loaded or continued and no write is started. Stored contents are kept.
- R12: With `rst_ni` low, no access is active and the output is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | LANES*LANE_W | Write data |
| ctl_strobe_n_i | input | 1 | Controller address strobe, active low, may write |
| cpu_strobe_n_i | input | 1 | Processor address strobe, active low, read start |
| advance_n_i | input | 1 | Burst advance, active low |
| order_lin_i | input | 1 | 1 selects linear order, 0 selects interleaved |
| sel_n_i | input | 1 | Chip select, active low |
| sel_hi_i | input | 1 | Chip select, active high |
| sel2_n_i | input | 1 | Second chip select, active low |
| lane_we_n_i | input | LANES | Per-lane write enables, active low |
| all_we_n_i | input | 1 | Global write, active low |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Blocks new accesses, keeps contents |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_oe_o | output | 1 | High while read data is driven |

## Verification
The bench builds the block with `ADDR_W` set to 5, which gives a 32-word array. Bursts can then start at a base whose low bits are 01, so both the interleaved and the linear order are exercised, including the modulo-4 wrap. Lane 9 bits wide and 2 lanes are the defaults, so a lane write shows up as an exact 9-bit field change and the parity bits are covered by those writes.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int BURST_W = 2;

  typedef logic [BURST_W-1:0] offs_t;

  // low address bits of a burst beat: interleaved = XOR, linear = modulo add
  function automatic offs_t beat_low(offs_t base, offs_t offs, logic lin);
    return lin ? offs_t'(base + offs) : (base ^ offs);
  endfunction
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ctl_strobe_n_i,
  input  logic              cpu_strobe_n_i,
  input  logic              advance_n_i,
  input  logic              sel_n_i,
  input  logic              sel_hi_i,
  input  logic              sel2_n_i,
  input  logic [LANES-1:0]  lane_we_n_i,
  input  logic              all_we_n_i,
  input  logic              sleep_i,
  output logic [ADDR_W-1:0] base_o,
  output offs_t             offs_o,
  output logic              active_o,
  output logic [LANES-1:0]  wr_lanes_o,
  output logic [WORD_W-1:0] wdata_o
);
  logic             selected, ctl_ld, cpu_ld, load;
  logic [LANES-1:0] lane_req;

  assign selected = !sel_n_i && sel_hi_i && !sel2_n_i;
  assign ctl_ld   = !ctl_strobe_n_i;
  assign cpu_ld   = !cpu_strobe_n_i && !sel_n_i;
  assign load     = (ctl_ld || cpu_ld) && !sleep_i;
  assign lane_req = all_we_n_i ? ~lane_we_n_i : {LANES{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o     <= '0;
      offs_o     <= '0;
      active_o   <= 1'b0;
      wr_lanes_o <= '0;
      wdata_o    <= '0;
    end else if (sleep_i) begin
      active_o   <= 1'b0;
      wr_lanes_o <= '0;
    end else if (load) begin
      base_o     <= addr_i;
      offs_o     <= '0;
      active_o   <= selected;
      // processor strobe alone always opens a read
      wr_lanes_o <= (selected && ctl_ld) ? lane_req : '0;
      wdata_o    <= wdata_i;
    end else if (active_o) begin
      if (!advance_n_i) offs_o <= offs_t'(offs_o + 1'b1);
      wr_lanes_o <= lane_req;
      wdata_o    <= wdata_i;
    end else begin
      wr_lanes_o <= '0;
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] base_i,
  input  offs_t             offs_i,
  input  logic              order_lin_i,
  output logic [ADDR_W-1:0] addr_o
);
  generate
    if (ADDR_W > BURST_W) begin : g_wide
      assign addr_o = {base_i[ADDR_W-1:BURST_W],
                       beat_low(base_i[BURST_W-1:0], offs_i, order_lin_i)};
    end else begin : g_narrow
      assign addr_o = beat_low(base_i[BURST_W-1:0], offs_i, order_lin_i);
    end
  endgenerate
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/burst_sram_ft.sv
module burst_sram_ft
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ctl_strobe_n_i,
  input  logic              cpu_strobe_n_i,
  input  logic              advance_n_i,
  input  logic              order_lin_i,
  input  logic              sel_n_i,
  input  logic              sel_hi_i,
  input  logic              sel2_n_i,
  input  logic [LANES-1:0]  lane_we_n_i,
  input  logic              all_we_n_i,
  input  logic              out_en_n_i,
  input  logic              sleep_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  logic [ADDR_W-1:0] base_q, cur_addr;
  offs_t             offs_q;
  logic              active_q;
  logic [LANES-1:0]  wr_lanes_q;
  logic [WORD_W-1:0] wdata_q, rd_word;

  burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .ctl_strobe_n_i, .cpu_strobe_n_i,
    .advance_n_i, .sel_n_i, .sel_hi_i, .sel2_n_i, .lane_we_n_i, .all_we_n_i,
    .sleep_i,
    .base_o(base_q), .offs_o(offs_q), .active_o(active_q),
    .wr_lanes_o(wr_lanes_q), .wdata_o(wdata_q)
  );

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .base_i(base_q), .offs_i(offs_q), .order_lin_i, .addr_o(cur_addr)
  );

  sram_lane_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank (
    .clk_i, .addr_i(cur_addr), .we_i(wr_lanes_q), .wdata_i(wdata_q),
    .rdata_o(rd_word)
  );

  // flow-through: no output register, enable is asynchronous
  assign rdata_oe_o = active_q && (wr_lanes_q == '0) && !out_en_n_i;
  assign rdata_o    = rdata_oe_o ? rd_word : '0;
endmodule

// File: rtl/burst_sram_ft_chk.sv
module burst_sram_ft_chk
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctl_strobe_n_i,
  input logic              cpu_strobe_n_i,
  input logic              advance_n_i,
  input logic              sel_n_i,
  input logic              sel_hi_i,
  input logic              sel2_n_i,
  input logic              all_we_n_i,
  input logic              sleep_i,
  input logic              out_en_n_i,
  input logic              rdata_oe_o,
  input logic              active_q,
  input logic [LANES-1:0]  wr_lanes_q,
  input offs_t             offs_q,
  input logic [ADDR_W-1:0] cur_addr
);
  logic sel_ok, cpu_only;
  assign sel_ok   = !sel_n_i && sel_hi_i && !sel2_n_i;
  assign cpu_only = ctl_strobe_n_i && !cpu_strobe_n_i && !sel_n_i;

  assert_deselect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_strobe_n_i && !sel_ok && !sleep_i) |=> !active_q && !rdata_oe_o);

  assert_cpu_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_only && sel_ok && !sleep_i) |=> active_q && (wr_lanes_q == '0));

  assert_offs_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !advance_n_i && ctl_strobe_n_i && (cpu_strobe_n_i || sel_n_i) && !sleep_i)
      |=> offs_q == offs_t'($past(offs_q) + 1'b1));

  assert_upper_fixed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && ctl_strobe_n_i && (cpu_strobe_n_i || sel_n_i) && !sleep_i)
      |=> $stable(cur_addr[ADDR_W-1:BURST_W]));

  assert_global_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_strobe_n_i && sel_ok && !all_we_n_i && !sleep_i) |=> wr_lanes_q == '1);

  assert_oe_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_n_i |-> !rdata_oe_o);

  assert_sleep_block_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !active_q && (wr_lanes_q == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R12: assert (!rdata_oe_o && !active_q);
  end
endmodule

bind burst_sram_ft burst_sram_ft_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk_i, .rst_ni, .ctl_strobe_n_i, .cpu_strobe_n_i, .advance_n_i, .sel_n_i,
  .sel_hi_i, .sel2_n_i, .all_we_n_i, .sleep_i, .out_en_n_i, .rdata_oe_o,
  .active_q, .wr_lanes_q, .offs_q, .cur_addr
);

// File: tb/burst_sram_ft_test.sv
module burst_sram_ft_test;
  localparam int AW = 5;
  localparam int WW = 18;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic          ctl_n = 1'b1, cpu_n = 1'b1, adv_n = 1'b1, lin = 1'b0;
  logic          sel_n = 1'b0, sel_hi = 1'b1, sel2_n = 1'b0;
  logic [1:0]    bw_n = 2'b11;
  logic          gw_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [WW-1:0] rdata;
  logic          rdata_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_sram_ft #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wdata_i(wdata),
    .ctl_strobe_n_i(ctl_n), .cpu_strobe_n_i(cpu_n), .advance_n_i(adv_n),
    .order_lin_i(lin), .sel_n_i(sel_n), .sel_hi_i(sel_hi), .sel2_n_i(sel2_n),
    .lane_we_n_i(bw_n), .all_we_n_i(gw_n), .out_en_n_i(oe_n), .sleep_i(sleep),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  typedef struct packed {
    logic          ctl_n, cpu_n, adv_n, gw_n;
    logic [1:0]    bw_n;
    logic          lin;
    logic [AW-1:0] addr;
    logic [WW-1:0] wd;
    logic          exp_oe;
    logic [WW-1:0] exp_d;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,5'd5, 18'h11111,1'b0,18'h0},     // R9 burst write base 5
    '{1'b1,1'b1,1'b0,1'b0,2'b11,1'b0,5'd5, 18'h22222,1'b0,18'h0},     // addr 4
    '{1'b1,1'b1,1'b0,1'b0,2'b11,1'b0,5'd5, 18'h33333,1'b0,18'h0},     // addr 7
    '{1'b1,1'b1,1'b0,1'b0,2'b11,1'b0,5'd5, 18'h04444,1'b0,18'h0},     // addr 6
    '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,5'd5, 18'h0,1'b1,18'h11111},     // R1 read 5
    '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b0,5'd0, 18'h0,1'b1,18'h22222},     // R6 4
    '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b0,5'd0, 18'h0,1'b1,18'h33333},     // R6 7
    '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b0,5'd0, 18'h0,1'b1,18'h04444},     // R6 6
    '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b0,5'd0, 18'h0,1'b1,18'h11111},     // R6 wrap 5
    '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,5'd5, 18'h0,1'b1,18'h11111},     // R7 linear 5
    '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,5'd0, 18'h0,1'b1,18'h04444},     // R7 6
    '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,5'd0, 18'h0,1'b1,18'h33333},     // R7 7
    '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,5'd0, 18'h0,1'b1,18'h22222},     // R7 wrap 4
    '{1'b1,1'b1,1'b1,1'b1,2'b11,1'b1,5'd0, 18'h0,1'b1,18'h22222},     // R5 hold 4
    '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,5'd9, 18'h0,1'b0,18'h0},         // clear 9
    '{1'b0,1'b1,1'b1,1'b1,2'b10,1'b0,5'd9, 18'h3FFFF,1'b0,18'h0},     // R8 lane a
    '{1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,5'd9, 18'h0,1'b1,18'h001FF},     // R8
    '{1'b0,1'b1,1'b1,1'b1,2'b01,1'b0,5'd9, 18'h3FFFF,1'b0,18'h0},     // R8 lane b
    '{1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,5'd9, 18'h0,1'b1,18'h3FFFF},     // R8
    '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,5'd10,18'h2A955,1'b0,18'h0},     // R9 override
    '{1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,5'd10,18'h0,1'b1,18'h2A955},     // R9
    '{1'b0,1'b0,1'b1,1'b0,2'b11,1'b0,5'd10,18'h15AAA,1'b0,18'h0},     // R3 both low
    '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,5'd10,18'h0,1'b1,18'h15AAA},     // R3
    '{1'b1,1'b0,1'b1,1'b0,2'b11,1'b0,5'd10,18'h0,1'b1,18'h15AAA},     // R4 read only
    '{1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,5'd10,18'h0,1'b1,18'h15AAA}      // R4 kept
  };

  function automatic string row_req(int i);
    if (i < 4)  return "R9";
    if (i == 4) return "R1";
    if (i < 9)  return "R6";
    if (i < 13) return "R7";
    if (i == 13) return "R5";
    if (i < 19) return "R8";
    if (i < 21) return "R9";
    if (i < 23) return "R3";
    return "R4";
  endfunction

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic p, input logic a, input logic g,
                       input logic [1:0] b, input logic l, input logic [AW-1:0] ad,
                       input logic [WW-1:0] d);
    ctl_n = c; cpu_n = p; adv_n = a; gw_n = g; bw_n = b; lin = l; addr = ad; wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R12: selected load under reset does nothing
    ctl_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R12 oe in reset", {17'b0, rdata_oe}, 18'h0);
    chk("R12 data in reset", rdata, 18'h0);
    ctl_n = 1'b1;
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].ctl_n, VEC[i].cpu_n, VEC[i].adv_n, VEC[i].gw_n, VEC[i].bw_n,
            VEC[i].lin, VEC[i].addr, VEC[i].wd);
      chk({row_req(i), " table oe"}, {17'b0, rdata_oe}, {17'b0, VEC[i].exp_oe});
      chk({row_req(i), " table data"}, rdata, VEC[i].exp_d);
    end

    // R10: asynchronous output enable
    oe_n = 1'b1;
    drive(1, 0, 1, 1, 2'b11, 0, 5'd5, 0);
    chk("R10 oe high undriven", {17'b0, rdata_oe}, 18'h0);
    chk("R10 oe high zero data", rdata, 18'h0);
    #1 oe_n = 1'b0;
    #1 chk("R10 oe low no edge", rdata, 18'h11111);

    // R2: deselected load ends burst
    sel_hi = 1'b0;
    drive(0, 1, 1, 1, 2'b11, 0, 5'd9, 0);
    chk("R2 deselected", {17'b0, rdata_oe}, 18'h0);
    sel_hi = 1'b1;
    drive(1, 1, 0, 1, 2'b11, 0, 5'd9, 0);
    chk("R2 no burst after deselect", {17'b0, rdata_oe}, 18'h0);
    sel2_n = 1'b1;
    drive(0, 1, 1, 1, 2'b11, 0, 5'd9, 0);
    chk("R2 second select", {17'b0, rdata_oe}, 18'h0);
    sel2_n = 1'b0;

    // R3: processor strobe ignored while sel_n high
    drive(1, 0, 1, 1, 2'b11, 0, 5'd5, 0);
    chk("R3 setup read 5", rdata, 18'h11111);
    sel_n = 1'b1;
    drive(1, 0, 1, 1, 2'b11, 0, 5'd10, 0);
    chk("R3 strobe ignored", rdata, 18'h11111);
    sel_n = 1'b0;

    // R11: sleep blocks a write, contents kept
    sleep = 1'b1;
    drive(0, 1, 1, 0, 2'b11, 0, 5'd5, 18'h0);
    chk("R11 asleep", {17'b0, rdata_oe}, 18'h0);
    sleep = 1'b0;
    drive(0, 1, 1, 1, 2'b11, 0, 5'd5, 0);
    chk("R11 contents kept", rdata, 18'h11111);

    // R12: asynchronous reset mid-access
    #1 rst_ni = 1'b0;
    #1 chk("R12 async reset", {17'b0, rdata_oe}, 18'h0);
    rst_ni = 1'b1;

    done = 1;
    summary();
    $finish;
  end
endmodule